// File: doc/BRIEF.md
# Selective ECC shield for a register file

The shield sits beside a physical register file and protects only a few register versions: the ones predicted to live longest. It keeps an 8-entry tagged side table. Each entry holds a physical register number, a valid bit, a pinned bit, a 2-bit lifetime score and the 7 SECDED check bits of the stored word. Up to three register writes arrive each cycle. For each write the shield decides whether the version gets an entry. If it does, the shield encodes the data and stores the check bits.

Register reads go to the normal datapath and, in parallel, to the shield on up to three read ports. A read whose register number matches a valid tag is decoded against the stored check bits. When a single-bit error is found, the shield raises a stall and a corrected-data writeback to the register file. It also raises a flush request naming the register, so the pipeline can restart from the oldest reader. A double-bit error raises the stall and an uncorrectable flag instead.

Entries can be pinned to a register number, for example one that holds a global pointer. Pinned entries are never replaced or released. Releasing a physical register frees its unpinned entry.

Top module: `ecc_shield`

## Requirements
- R1: After reset every table entry is invalid and unpinned, and stall, wbValid, flushValid and uncorrectable are 0, so a read of any register raises nothing.
- R2: A read hitting a valid entry with exactly one flipped data bit sets stall, wbValid and flushValid in the next cycle. In that cycle wbPreg and flushPreg equal the read register and wbData equals the word originally written.
- R3: A read hitting a valid entry with two flipped data bits sets stall and uncorrectable in the next cycle, with wbValid and flushValid at 0.
- R4: A write to a register number already held in the table overwrites that same entry, so the newest data is protected and no second entry is used.
- R5: A write with no matching tag takes the lowest-index entry that is neither valid nor pinned.
- R6: With no free entry, a write replaces the unpinned valid entry with the smallest lifetime score strictly below its own score (lowest index on ties). The score is 2*used + (1 - renamed), from the wrUsed and wrRenamed bits. If no entry scores lower, the version is not protected.
- R7: Read data is decoded only when its register number matches a valid tag; a miss or a clean hit leaves all recovery outputs at 0.
- R8: Three writes in one cycle are allocated in port order 0, 1, 2. A later port sees the table as updated by earlier ports, and for the same register number the later port's data is kept.
- R9: pinReq with pinIdx and pinPreg makes entry pinIdx pinned to pinPreg and invalid. It becomes valid on a write to pinPreg. A pinned entry is never replaced by another register and is not cleared by release.
- R10: relValid with relPreg invalidates an unpinned valid entry tagged relPreg; later reads of it raise nothing. A release is applied before the same cycle's writes.
- R11: When several read ports find errors in one cycle, the lowest-numbered erroring port is the one reported, including its correctable or uncorrectable kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 3 | Per write port: write this cycle |
| wrPreg | input | 3x7 | Per write port: physical register number |
| wrData | input | 3x32 | Per write port: data written |
| wrUsed | input | 3 | Per write port: predicted read at least once |
| wrRenamed | input | 3 | Per write port: predicted renamed |
| rdValid | input | 3 | Per read port: read this cycle |
| rdPreg | input | 3x7 | Per read port: physical register number |
| rdData | input | 3x32 | Per read port: data read from the register file |
| relValid | input | 1 | Release a physical register |
| relPreg | input | 7 | Register released |
| pinReq | input | 1 | Pin an entry to a register number |
| pinIdx | input | 3 | Entry to pin |
| pinPreg | input | 7 | Register number the entry is pinned to |
| stall | output | 1 | Error found on a checked read |
| wbValid | output | 1 | Corrected data writeback request |
| wbPreg | output | 7 | Register to write back |
| wbData | output | 32 | Corrected data |
| flushValid | output | 1 | Flush from the oldest reader of flushPreg |
| flushPreg | output | 7 | Register whose readers are flushed |
| uncorrectable | output | 1 | Double error detected |

## Verification
All recovery outputs are registered, so they are due in the cycle after the read is presented. Table updates from a write, release or pin are visible to a read presented in the cycle after that update. The bench drives inputs just after a rising edge, lets one edge pass and samples just after it. Allocation decisions are observed only through the ports: a read with a deliberately flipped bit raises a stall exactly when the register holds an entry.

// File: rtl/shield_pkg.sv
`timescale 1ns/1ps
package shield_pkg;
  localparam int DATA_W   = 32;
  localparam int HAM_W    = 6;
  localparam int CHK_W    = HAM_W + 1;
  localparam int CODE_LEN = DATA_W + HAM_W;
  localparam int ENTRIES  = 8;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int NPORT    = 3;
  localparam int PREG_W   = 7;
  localparam int SCORE_W  = 2;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [PREG_W-1:0] preg_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic [NPORT-1:0]            wrEn;
    logic [NPORT-1:0][IDX_W-1:0] wrIdx;
    logic [NPORT-1:0]            rdHit;
    logic [NPORT-1:0][IDX_W-1:0] rdIdx;
  } strobe_t;

  typedef struct packed {
    logic  err;
    logic  dbl;
    word_t fixed;
  } chk_res_t;

  // XOR of codeword positions of all set data bits (positions skip powers of two)
  function automatic logic [HAM_W-1:0] hamBits(word_t d);
    logic [HAM_W-1:0] h;
    int di;
    h  = '0;
    di = 0;
    for (int pos = 1; pos <= CODE_LEN; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[di]) h = h ^ HAM_W'(pos);
        di++;
      end
    end
    return h;
  endfunction

  function automatic chk_t eccEncode(word_t d);
    logic [HAM_W-1:0] h;
    h = hamBits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic chk_res_t eccCheck(word_t d, chk_t c);
    logic [HAM_W-1:0] syn;
    logic par;
    chk_res_t r;
    int di;
    syn     = hamBits(d) ^ c[HAM_W-1:0];
    par     = (^d) ^ (^c);
    r.err   = (syn != '0) || par;
    r.dbl   = (syn != '0) && !par;
    r.fixed = d;
    di      = 0;
    for (int pos = 1; pos <= CODE_LEN; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (par && (syn == HAM_W'(pos))) r.fixed[di] = ~d[di];
        di++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/shield_ctrl.sv
`timescale 1ns/1ps
module shield_ctrl
  import shield_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORT-1:0]             wrValid,
  input  logic [NPORT-1:0][PREG_W-1:0] wrPreg,
  input  logic [NPORT-1:0]             wrUsed,
  input  logic [NPORT-1:0]             wrRenamed,
  input  logic [NPORT-1:0]             rdValid,
  input  logic [NPORT-1:0][PREG_W-1:0] rdPreg,
  input  logic                         relValid,
  input  logic [PREG_W-1:0]            relPreg,
  input  logic                         pinReq,
  input  logic [IDX_W-1:0]             pinIdx,
  input  logic [PREG_W-1:0]            pinPreg,
  output strobe_t                      strobe
);
  logic [ENTRIES-1:0]              vldQ, vldD, pinQ, pinD;
  logic [ENTRIES-1:0][PREG_W-1:0]  tagQ, tagD;
  logic [ENTRIES-1:0][SCORE_W-1:0] scoreQ, scoreD;

  always_comb begin : nextTable
    logic found;
    idx_t sel;
    logic [SCORE_W-1:0] inScore, best;
    vldD   = vldQ;
    pinD   = pinQ;
    tagD   = tagQ;
    scoreD = scoreQ;
    strobe = '0;
    found   = 1'b0;
    sel     = '0;
    inScore = '0;
    best    = '0;
    if (pinReq) begin
      tagD[pinIdx] = pinPreg;
      pinD[pinIdx] = 1'b1;
      vldD[pinIdx] = 1'b0;
    end
    if (relValid) begin
      for (int e = 0; e < ENTRIES; e++)
        if (vldD[e] && !pinD[e] && tagD[e] == relPreg) vldD[e] = 1'b0;
    end
    for (int p = 0; p < NPORT; p++) begin
      found   = 1'b0;
      sel     = '0;
      inScore = {wrUsed[p], ~wrRenamed[p]};
      best    = inScore;
      if (wrValid[p]) begin
        for (int e = 0; e < ENTRIES; e++)
          if (!found && (vldD[e] || pinD[e]) && tagD[e] == wrPreg[p]) begin
            found = 1'b1;
            sel   = IDX_W'(e);
          end
        for (int e = 0; e < ENTRIES; e++)
          if (!found && !vldD[e] && !pinD[e]) begin
            found = 1'b1;
            sel   = IDX_W'(e);
          end
        if (!found) begin
          for (int e = 0; e < ENTRIES; e++)
            if (vldD[e] && !pinD[e] && scoreD[e] < best) begin
              best  = scoreD[e];
              sel   = IDX_W'(e);
              found = 1'b1;
            end
        end
        if (found) begin
          vldD[sel]        = 1'b1;
          tagD[sel]        = wrPreg[p];
          scoreD[sel]      = inScore;
          strobe.wrEn[p]   = 1'b1;
          strobe.wrIdx[p]  = sel;
        end
      end
    end
    for (int p = 0; p < NPORT; p++) begin
      for (int e = ENTRIES - 1; e >= 0; e--)
        if (rdValid[p] && vldQ[e] && tagQ[e] == rdPreg[p]) begin
          strobe.rdHit[p] = 1'b1;
          strobe.rdIdx[p] = IDX_W'(e);
        end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ   <= '0;
      pinQ   <= '0;
      tagQ   <= '0;
      scoreQ <= '0;
    end else begin
      vldQ   <= vldD;
      pinQ   <= pinD;
      tagQ   <= tagD;
      scoreQ <= scoreD;
    end
  end
endmodule

// File: rtl/shield_dp.sv
`timescale 1ns/1ps
module shield_dp
  import shield_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  logic [NPORT-1:0][DATA_W-1:0] wrData,
  input  logic [NPORT-1:0][PREG_W-1:0] rdPreg,
  input  logic [NPORT-1:0][DATA_W-1:0] rdData,
  output logic                         stall,
  output logic                         wbValid,
  output logic [PREG_W-1:0]            wbPreg,
  output logic [DATA_W-1:0]            wbData,
  output logic                         flushValid,
  output logic [PREG_W-1:0]            flushPreg,
  output logic                         uncorrectable
);
  chk_t     chkQ [ENTRIES];
  chk_t     encW [NPORT];
  chk_res_t res  [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign encW[p] = eccEncode(wrData[p]);
    assign res[p]  = eccCheck(rdData[p], chkQ[strobe.rdIdx[p]]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) chkQ[e] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (strobe.wrEn[p]) chkQ[strobe.wrIdx[p]] <= encW[p];
    end
  end

  logic  anyErr, isDbl;
  preg_t errPreg;
  word_t errData;

  always_comb begin
    anyErr  = 1'b0;
    isDbl   = 1'b0;
    errPreg = '0;
    errData = '0;
    for (int p = 0; p < NPORT; p++)
      if (!anyErr && strobe.rdHit[p] && res[p].err) begin
        anyErr  = 1'b1;
        isDbl   = res[p].dbl;
        errPreg = rdPreg[p];
        errData = res[p].fixed;
      end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stall         <= 1'b0;
      wbValid       <= 1'b0;
      wbPreg        <= '0;
      wbData        <= '0;
      flushValid    <= 1'b0;
      flushPreg     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      stall         <= anyErr;
      wbValid       <= anyErr && !isDbl;
      wbPreg        <= errPreg;
      wbData        <= errData;
      flushValid    <= anyErr && !isDbl;
      flushPreg     <= errPreg;
      uncorrectable <= anyErr && isDbl;
    end
  end
endmodule

// File: rtl/ecc_shield.sv
`timescale 1ns/1ps
module ecc_shield
  import shield_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORT-1:0]             wrValid,
  input  logic [NPORT-1:0][PREG_W-1:0] wrPreg,
  input  logic [NPORT-1:0][DATA_W-1:0] wrData,
  input  logic [NPORT-1:0]             wrUsed,
  input  logic [NPORT-1:0]             wrRenamed,
  input  logic [NPORT-1:0]             rdValid,
  input  logic [NPORT-1:0][PREG_W-1:0] rdPreg,
  input  logic [NPORT-1:0][DATA_W-1:0] rdData,
  input  logic                         relValid,
  input  logic [PREG_W-1:0]            relPreg,
  input  logic                         pinReq,
  input  logic [IDX_W-1:0]             pinIdx,
  input  logic [PREG_W-1:0]            pinPreg,
  output logic                         stall,
  output logic                         wbValid,
  output logic [PREG_W-1:0]            wbPreg,
  output logic [DATA_W-1:0]            wbData,
  output logic                         flushValid,
  output logic [PREG_W-1:0]            flushPreg,
  output logic                         uncorrectable
);
  strobe_t strobe;

  shield_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrPreg(wrPreg), .wrUsed(wrUsed), .wrRenamed(wrRenamed),
    .rdValid(rdValid), .rdPreg(rdPreg),
    .relValid(relValid), .relPreg(relPreg),
    .pinReq(pinReq), .pinIdx(pinIdx), .pinPreg(pinPreg),
    .strobe(strobe)
  );

  shield_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .rdPreg(rdPreg), .rdData(rdData),
    .stall(stall), .wbValid(wbValid), .wbPreg(wbPreg), .wbData(wbData),
    .flushValid(flushValid), .flushPreg(flushPreg), .uncorrectable(uncorrectable)
  );
endmodule

// File: rtl/shield_chk.sv
`timescale 1ns/1ps
module shield_chk
  import shield_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic [NPORT-1:0]                rdValid,
  input logic                            stall,
  input logic                            wbValid,
  input logic [PREG_W-1:0]               wbPreg,
  input logic                            flushValid,
  input logic [PREG_W-1:0]               flushPreg,
  input logic                            uncorrectable,
  input logic [ENTRIES-1:0]              vldQ,
  input logic [ENTRIES-1:0]              pinQ,
  input logic [ENTRIES-1:0][PREG_W-1:0]  tagQ
);
  // R1: coming out of reset nothing is valid and no stall is raised
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (vldQ == '0 && !stall));

  // R2: a writeback comes with a stall and a flush of the same register
  a_r2_wb_with_flush: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (stall && flushValid && flushPreg == wbPreg));

  // R3: a double error never requests a writeback
  a_r3_dbl_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    uncorrectable |-> (stall && !wbValid && !flushValid));

  // R7: a stall only follows a cycle with a read
  a_r7_stall_after_read: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> $past(|rdValid));

  // R9: a pinned entry stays pinned
  a_r9_pin_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pinQ & $past(pinQ)) == $past(pinQ));

  // R4: no two valid entries hold the same register number
  always @(posedge clk) begin
    if (rstN) begin
      for (int i = 0; i < ENTRIES; i++)
        for (int j = i + 1; j < ENTRIES; j++)
          a_r4_unique_tags: assert (!(vldQ[i] && vldQ[j] && tagQ[i] == tagQ[j]));
    end
  end
endmodule

bind ecc_shield shield_chk u_chk (
  .clk(clk), .rstN(rstN), .rdValid(rdValid),
  .stall(stall), .wbValid(wbValid), .wbPreg(wbPreg),
  .flushValid(flushValid), .flushPreg(flushPreg), .uncorrectable(uncorrectable),
  .vldQ(u_ctrl.vldQ), .pinQ(u_ctrl.pinQ), .tagQ(u_ctrl.tagQ)
);

// File: tb/ecc_shield_tb.sv
`timescale 1ns/1ps
module ecc_shield_tb;
  import shield_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NPORT-1:0]             wrValid, wrUsed, wrRenamed, rdValid;
  logic [NPORT-1:0][PREG_W-1:0] wrPreg, rdPreg;
  logic [NPORT-1:0][DATA_W-1:0] wrData, rdData;
  logic relValid, pinReq;
  logic [PREG_W-1:0] relPreg, pinPreg;
  logic [IDX_W-1:0]  pinIdx;
  logic stall, wbValid, flushValid, uncorrectable;
  logic [PREG_W-1:0] wbPreg, flushPreg;
  logic [DATA_W-1:0] wbData;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_shield u_dut (.*);

  task automatic clearIn();
    wrValid = '0; wrUsed = '0; wrRenamed = '0; wrPreg = '0; wrData = '0;
    rdValid = '0; rdPreg = '0; rdData = '0;
    relValid = 1'b0; relPreg = '0; pinReq = 1'b0; pinIdx = '0; pinPreg = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    clearIn();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic setWr(int p, int preg, logic [31:0] d, bit used, bit ren);
    wrValid[p] = 1'b1; wrPreg[p] = PREG_W'(preg); wrData[p] = d;
    wrUsed[p] = used; wrRenamed[p] = ren;
  endtask

  task automatic wr1(int preg, logic [31:0] d, bit used, bit ren);
    clearIn(); setWr(0, preg, d, used, ren); tick(); clearIn();
  endtask

  task automatic setRd(int p, int preg, logic [31:0] d);
    rdValid[p] = 1'b1; rdPreg[p] = PREG_W'(preg); rdData[p] = d;
  endtask

  // read on one port, results due one edge later
  task automatic expectFix(string req, int p, int preg, logic [31:0] d, logic [31:0] good);
    clearIn(); setRd(p, preg, d); tick(); clearIn();
    check({req, " stall"}, 32'(stall), 1);
    check({req, " wbValid"}, 32'(wbValid), 1);
    check({req, " wbPreg"}, 32'(wbPreg), preg);
    check({req, " wbData"}, wbData, good);
    check({req, " flush"}, {31'(flushPreg), flushValid}, {31'(preg), 1'b1});
    check({req, " uncorr"}, 32'(uncorrectable), 0);
  endtask

  task automatic expectQuiet(string req, int p, int preg, logic [31:0] d);
    clearIn(); setRd(p, preg, d); tick(); clearIn();
    check({req, " quiet"}, {28'(0), stall, wbValid, flushValid, uncorrectable}, 0);
  endtask

  task automatic testReset();
    doReset();
    check("R1 outputs", {28'(0), stall, wbValid, flushValid, uncorrectable}, 0);
    expectQuiet("R1", 0, 5, 32'hDEAD_BEEF);
  endtask

  task automatic testSingle();
    doReset();
    wr1(10, 32'h1234_5678, 1, 0);
    expectFix("R2 bit7", 0, 10, 32'h1234_5678 ^ (32'h1 << 7), 32'h1234_5678);
    expectFix("R2 bit0", 1, 10, 32'h1234_5678 ^ 32'h1, 32'h1234_5678);
    expectFix("R2 bit31", 2, 10, 32'h1234_5678 ^ 32'h8000_0000, 32'h1234_5678);
    expectQuiet("R7 clean", 0, 10, 32'h1234_5678);
    expectQuiet("R7 miss", 0, 11, 32'h0000_0001);
  endtask

  task automatic testDouble();
    doReset();
    wr1(12, 32'hA5A5_0F0F, 0, 0);
    clearIn(); setRd(2, 12, 32'hA5A5_0F0F ^ 32'h0000_0300); tick(); clearIn();
    check("R3 stall", 32'(stall), 1);
    check("R3 uncorr", 32'(uncorrectable), 1);
    check("R3 nowb", {30'(0), wbValid, flushValid}, 0);
  endtask

  task automatic testDupFill();
    doReset();
    wr1(20, 32'h0000_AAAA, 1, 0);
    wr1(20, 32'h5555_0000, 1, 0);
    for (int i = 0; i < 7; i++) wr1(21 + i, 32'h1000_0000 + 32'(i * 77), 1, 0);
    wr1(40, 32'h0BAD_F00D, 1, 0);
    expectFix("R4 newest", 0, 20, 32'h5555_0000 ^ 32'h10, 32'h5555_0000);
    for (int i = 0; i < 7; i++)
      expectFix("R5 fill", 0, 21 + i, (32'h1000_0000 + 32'(i * 77)) ^ (32'h1 << i),
                32'h1000_0000 + 32'(i * 77));
    expectQuiet("R6 no shorter", 0, 40, 32'h0BAD_F00D ^ 32'h1);
  endtask

  task automatic testReplace();
    doReset();
    // scores 3,1,2,1,3,3,3,3 for registers 30..37
    wr1(30, 32'h30, 1, 0); wr1(31, 32'h31, 0, 0); wr1(32, 32'h32, 1, 1);
    wr1(33, 32'h33, 0, 0); wr1(34, 32'h34, 1, 0); wr1(35, 32'h35, 1, 0);
    wr1(36, 32'h36, 1, 0); wr1(37, 32'h37, 1, 0);
    wr1(40, 32'h40, 1, 1);  // score 2 replaces lowest-index score-1 entry (31)
    expectQuiet("R6 evicted", 0, 31, 32'h31 ^ 32'h100);
    expectFix("R6 placed", 0, 40, 32'h40 ^ 32'h100, 32'h40);
    expectFix("R6 tie kept", 0, 33, 32'h33 ^ 32'h100, 32'h33);
    wr1(41, 32'h41, 0, 0);  // score 1, nothing strictly shorter
    expectQuiet("R6 equal", 0, 41, 32'h41 ^ 32'h2);
    expectFix("R6 still", 0, 33, 32'h33 ^ 32'h2, 32'h33);
    wr1(41, 32'h41, 1, 0);  // score 3 replaces minimum score (33)
    expectQuiet("R6 min evict", 0, 33, 32'h33 ^ 32'h4);
    expectFix("R6 min placed", 0, 41, 32'h41 ^ 32'h4, 32'h41);
    expectFix("R6 kept 32", 0, 32, 32'h32 ^ 32'h4, 32'h32);
  endtask

  task automatic testRelease();
    doReset();
    wr1(50, 32'h5050_5050, 1, 0);
    wr1(51, 32'h5151_5151, 1, 0);
    clearIn(); relValid = 1'b1; relPreg = 7'd50; tick(); clearIn();
    expectQuiet("R10 released", 0, 50, 32'h5050_5050 ^ 32'h8);
    expectFix("R10 other", 0, 51, 32'h5151_5151 ^ 32'h8, 32'h5151_5151);
  endtask

  task automatic testPin();
    doReset();
    clearIn(); pinReq = 1'b1; pinIdx = '0; pinPreg = 7'd60; tick(); clearIn();
    expectQuiet("R9 pinned empty", 0, 60, 32'h1);
    wr1(60, 32'h6060_0000, 0, 1);
    for (int i = 0; i < 7; i++) wr1(61 + i, 32'h6100_0000 + 32'(i), 1, 0);
    wr1(70, 32'h7070_7070, 1, 0);
    expectQuiet("R9 not replaced", 0, 70, 32'h7070_7070 ^ 32'h1);
    expectFix("R9 pinned data", 0, 60, 32'h6060_0000 ^ 32'h20, 32'h6060_0000);
    clearIn(); relValid = 1'b1; relPreg = 7'd60; tick(); clearIn();
    expectFix("R9 survives release", 0, 60, 32'h6060_0000 ^ 32'h40, 32'h6060_0000);
  endtask

  task automatic testMulti();
    doReset();
    for (int i = 0; i < 6; i++) begin
      clearIn(); setWr(i % 3, 80 + i, 32'h8000_0000 + 32'(i), 1, 0); tick(); clearIn();
    end
    clearIn();
    setWr(0, 90, 32'h9090_0000, 1, 0);
    setWr(1, 91, 32'h9191_0000, 1, 0);
    setWr(2, 92, 32'h9292_0000, 1, 0);
    tick(); clearIn();
    expectFix("R8 port0", 1, 90, 32'h9090_0000 ^ 32'h1, 32'h9090_0000);
    expectFix("R8 port1", 2, 91, 32'h9191_0000 ^ 32'h1, 32'h9191_0000);
    expectQuiet("R8 port2 full", 0, 92, 32'h9292_0000 ^ 32'h1);
    doReset();
    clearIn();
    setWr(0, 95, 32'hAAAA_0000, 1, 0);
    setWr(1, 95, 32'hBBBB_0000, 1, 0);
    tick(); clearIn();
    expectFix("R8 later port wins", 0, 95, 32'hBBBB_0000 ^ 32'h80, 32'hBBBB_0000);
  endtask

  task automatic testPrio();
    doReset();
    wr1(100, 32'hC0DE_0100, 1, 0);
    wr1(101, 32'hC0DE_0101, 1, 0);
    clearIn();
    setRd(0, 100, 32'hC0DE_0100);
    setRd(1, 101, 32'hC0DE_0101 ^ 32'h10);
    setRd(2, 100, 32'hC0DE_0100 ^ 32'h200);
    tick(); clearIn();
    check("R11 preg", 32'(wbPreg), 101);
    check("R11 data", wbData, 32'hC0DE_0101);
    check("R11 kind", {30'(0), wbValid, uncorrectable}, 2);
    clearIn();
    setRd(0, 101, 32'hC0DE_0101 ^ 32'h3);
    setRd(2, 100, 32'hC0DE_0100 ^ 32'h200);
    tick(); clearIn();
    check("R11 dbl first", {29'(0), stall, wbValid, uncorrectable}, 3'b101);
  endtask

  initial begin
    clearIn();
    testReset();
    testSingle();
    testDouble();
    testDupFill();
    testReplace();
    testRelease();
    testPin();
    testMulti();
    testPrio();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule